// File: doc/BRIEF.md
# Erase Suspend Controller

This block owns a flash erase once the command decoder has accepted it. It receives a start strobe with a target bank, a per-bank block mask (or a whole-bank flag) and a per-block failure-injection mask. It then works through the selected blocks one after another, spending a fixed number of clock cycles on each block. That fixed count stands in for the pre-program to 00h and the erase to FFh. A block named in the injection mask finishes with a failure.

While the erase owns a bank, reads of that bank return a status byte instead of array data. The block drives the polling, toggle, failure, timer and per-block toggle bits of that byte, plus a select that tells the read path whether to take status or array data. A block erase can be suspended. Once the suspend latency has run out, the progress counter freezes. Reads of the erasing blocks then return suspend status, and reads of any other block return array data. A short program can also run on a block that is not being erased. A resume addressed to the erasing bank continues the erase from the exact point where it stopped.

Block addresses are `{bank, local}`: the most significant bit selects bank 0 or bank 1, and the low bits select the block inside that bank.

Top module: `erase_suspend_ctl`

## Requirements
- R1: During and after reset, `busy_o`, `suspended_o` and `sel_status_o` are 0 and the idle status byte has bit 7 at 1.
- R2: A start strobe while idle erases the masked blocks of the chosen bank, or every block of it when the whole-bank flag is set. `busy_o` is 1 for exactly ERASE_CYC clock cycles per selected block. A start with an empty mask and no whole-bank flag is ignored.
- R3: While the erase runs, a read of a block in the erasing bank drives `sel_status_o`=1 with stat bit 7 = 0, bit 5 = 0 and bit 3 = 1. Bit 2 flips after each read of an erasing block and holds on reads of other blocks. A read of the other bank drives `sel_status_o`=0.
- R4: Stat bit 6 flips after every status read while the erase runs. After a successful finish, reads return array data, and the stat byte shows bit 7 = 1 with bit 6 held across reads.
- R5: If any block failed, then once the erase ends, reads of that bank show bit 5 = 1, bit 7 = 0 and bit 3 = 1. Bit 2 flips only on reads of a failed block. This state is left only by the read/reset strobe `rst_cmd_i`.
- R6: A suspend strobe is taken only while a block erase (not a whole-bank erase) runs. `suspended_o` rises exactly SUSP_LAT cycles after the strobe is taken, and `busy_o` falls at the same time.
- R7: While suspended, a read of an erasing block gives `sel_status_o`=1 with bit 6 = 1, bit 7 = 0 and bit 3 = 1, and bit 2 flips on each such read. A read of any block not being erased gives `sel_status_o`=0.
- R8: While suspended, a program strobe on a block not being erased runs for PROG_CYC cycles. During that time, reads of other non-erasing blocks in its bank give status with bit 3 = 0, bit 7 = 0 and bit 6 flipping on each read. A program strobe on an erasing block is ignored.
- R9: A resume strobe is taken only while suspended, with `cmd_blk_i` in the erasing bank and no program running. The erase then continues with its progress unchanged, so the total number of `busy_o` cycles equals the figure given in R2.
- R10: While the erase runs unsuspended, start, resume, program and read/reset strobes have no effect.
- R11: While suspended, start, suspend and read/reset strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Erase start strobe from the command decoder |
| start_bank_i | input | 1 | Bank to erase |
| whole_bank_i | input | 1 | 1: erase every block of the bank (not suspendable) |
| blk_mask_i | input | BLOCKS_PER_BANK | Blocks to erase within the bank |
| fail_inj_i | input | BLOCKS_PER_BANK | Blocks whose erase is to end in failure |
| sus_i | input | 1 | Decoded suspend strobe |
| res_i | input | 1 | Decoded resume strobe |
| prog_i | input | 1 | Decoded program-start strobe |
| rst_cmd_i | input | 1 | Decoded read/reset strobe |
| cmd_blk_i | input | LOC_W+1 | Block address of the resume or program command |
| rd_i | input | 1 | Bus read strobe, one per read |
| rd_blk_i | input | LOC_W+1 | Block address of the read |
| stat_o | output | 8 | Status byte (bits 7, 6, 5, 3, 2 used, others 0) |
| sel_status_o | output | 1 | 1: read data comes from stat_o, 0: from the array |
| busy_o | output | 1 | Erase progressing |
| suspended_o | output | 1 | Erase frozen in suspend |

## Verification
The hardest condition to reach is a suspend that holds while a program is running in it, with a resume arriving during that program. It needs an erase that has made partial progress, a suspend latency that has fully run out, and a program strobe on a block outside the erase mask, all before the resume. The stimulus starts a two-block erase and issues the suspend a few cycles in. It then waits out the latency, starts a program on a sibling block, and issues a resume in the middle of the program window. The bench then confirms, through reads and the total count of busy cycles, that this resume was refused and that the later valid resume lost no progress.

// File: rtl/fes_pkg.sv
package fes_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RUN,
      ST_SPEND,
      ST_SUSP,
      ST_FAIL
   } fes_state_e;

   typedef struct packed {
      logic poll;
      logic tog;
      logic fail;
      logic tmr;
      logic blkt;
   } fes_stat_t;

   function automatic logic [7:0] pack_stat(input fes_stat_t s);
      return {s.poll, s.tog, s.fail, 1'b0, s.tmr, s.blkt, 2'b00};
   endfunction

endpackage

// File: rtl/fes_lsb_pick.sv
// Picks the lowest set bit of a vector; gives one-hot and index forms.
module fes_lsb_pick #(
   parameter int W = 4,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec_i,
   output logic [W-1:0]  oh_o,
   output logic [IW-1:0] idx_o
);
   logic [W:0] seen;

   assign seen[0] = 1'b0;

   genvar g;
   generate
      for (g = 0; g < W; g++) begin : g_chain
         assign seen[g+1] = seen[g] | vec_i[g];
         assign oh_o[g]   = vec_i[g] & ~seen[g];
      end
   endgenerate

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < W; i++) begin
         if (oh_o[i]) idx_o = IW'(i);
      end
   end
endmodule

// File: rtl/fes_prog_timer.sv
// Models a program operation as a fixed run of PROG_CYC cycles.
module fes_prog_timer #(
   parameter int PROG_CYC = 5,
   localparam int CW = $clog2(PROG_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic bank_i,
   output logic busy_o,
   output logic bank_o
);
   logic [CW-1:0] cnt;

   generate
      if (PROG_CYC < 1) begin : g_bad_cyc
         $error("fes_prog_timer: PROG_CYC must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         bank_o <= 1'b0;
         cnt    <= '0;
      end else if (!busy_o) begin
         if (start_i) begin
            busy_o <= 1'b1;
            bank_o <= bank_i;
            cnt    <= '0;
         end
      end else if (cnt == CW'(PROG_CYC - 1)) begin
         busy_o <= 1'b0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/fes_status_mux.sv
// Builds the status byte and the read-path select for one read address.
module fes_status_mux
   import fes_pkg::*;
#(
   parameter int LOC_W = 2,
   localparam int NB = 1 << LOC_W
) (
   input  fes_state_e       state_i,
   input  logic             ebank_i,
   input  logic [NB-1:0]    eset_i,
   input  logic [NB-1:0]    failed_i,
   input  logic             prog_busy_i,
   input  logic             pbank_i,
   input  logic [LOC_W:0]   rd_blk_i,
   input  logic             tog6_i,
   input  logic             tog2_i,
   output logic             sel_o,
   output logic [7:0]       stat_o,
   output logic             flip6_o,
   output logic             flip2_o
);
   logic             rbank;
   logic [LOC_W-1:0] rloc;
   logic             same_bank;
   logic             in_set;
   logic             is_failed;
   fes_stat_t        st;

   assign rbank     = rd_blk_i[LOC_W];
   assign rloc      = rd_blk_i[LOC_W-1:0];
   assign same_bank = (rbank == ebank_i);
   assign in_set    = same_bank & eset_i[rloc];
   assign is_failed = same_bank & failed_i[rloc];

   always_comb begin
      st      = '{poll: 1'b1, tog: tog6_i, fail: 1'b0, tmr: 1'b0, blkt: tog2_i};
      sel_o   = 1'b0;
      flip6_o = 1'b0;
      flip2_o = 1'b0;
      case (state_i)
         ST_RUN, ST_SPEND: begin
            if (same_bank) begin
               sel_o   = 1'b1;
               st      = '{poll: 1'b0, tog: tog6_i, fail: 1'b0, tmr: 1'b1, blkt: tog2_i};
               flip6_o = 1'b1;
               flip2_o = in_set;
            end
         end
         ST_FAIL: begin
            if (same_bank) begin
               sel_o   = 1'b1;
               st      = '{poll: 1'b0, tog: tog6_i, fail: 1'b1, tmr: 1'b1, blkt: tog2_i};
               flip6_o = 1'b1;
               flip2_o = is_failed;
            end
         end
         ST_SUSP: begin
            if (in_set) begin
               sel_o   = 1'b1;
               st      = '{poll: 1'b0, tog: 1'b1, fail: 1'b0, tmr: 1'b1, blkt: tog2_i};
               flip2_o = 1'b1;
            end else if (prog_busy_i && (rbank == pbank_i)) begin
               sel_o   = 1'b1;
               st      = '{poll: 1'b0, tog: tog6_i, fail: 1'b0, tmr: 1'b0, blkt: 1'b0};
               flip6_o = 1'b1;
            end
         end
         default: ;
      endcase
      stat_o = pack_stat(st);
   end
endmodule

// File: rtl/erase_suspend_ctl.sv
// Erase sequencing, suspend/resume control and status generation.
module erase_suspend_ctl
   import fes_pkg::*;
#(
   parameter int BLOCKS_PER_BANK = 4,
   parameter int ERASE_CYC       = 16,
   parameter int SUSP_LAT        = 3,
   parameter int PROG_CYC        = 5,
   localparam int LOC_W = $clog2(BLOCKS_PER_BANK),
   localparam int BLK_W = LOC_W + 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic                       start_bank_i,
   input  logic                       whole_bank_i,
   input  logic [BLOCKS_PER_BANK-1:0] blk_mask_i,
   input  logic [BLOCKS_PER_BANK-1:0] fail_inj_i,
   input  logic                       sus_i,
   input  logic                       res_i,
   input  logic                       prog_i,
   input  logic                       rst_cmd_i,
   input  logic [BLK_W-1:0]           cmd_blk_i,
   input  logic                       rd_i,
   input  logic [BLK_W-1:0]           rd_blk_i,
   output logic [7:0]                 stat_o,
   output logic                       sel_status_o,
   output logic                       busy_o,
   output logic                       suspended_o
);
   localparam int NB = BLOCKS_PER_BANK;
   localparam int EW = $clog2(ERASE_CYC);
   localparam int SW = $clog2(SUSP_LAT + 1);

   generate
      if (NB < 2 || (NB & (NB - 1)) != 0) begin : g_bad_nb
         $error("erase_suspend_ctl: BLOCKS_PER_BANK must be a power of two >= 2");
      end
      if (ERASE_CYC < 2) begin : g_bad_ec
         $error("erase_suspend_ctl: ERASE_CYC must be at least 2");
      end
      if (SUSP_LAT < 1) begin : g_bad_sl
         $error("erase_suspend_ctl: SUSP_LAT must be at least 1");
      end
   endgenerate

   fes_state_e      state;
   logic [NB-1:0]   pend, eset, fail_lat, failed;
   logic            ebank, bmode;
   logic [EW-1:0]   ecnt;
   logic [SW-1:0]   scnt;
   logic            tog6, tog2;

   logic [NB-1:0]   pick_oh;
   logic [LOC_W-1:0] pick_idx;
   logic            prog_busy, pbank;
   logic            flip6, flip2;

   logic             cmd_bank;
   logic [LOC_W-1:0] cmd_loc;
   logic             cmd_in_set;
   logic             running, step_end, done;
   logic [NB-1:0]    pend_nx, failed_nx;
   logic             start_ok, sus_ok, res_ok, prog_ok, clr_ok;

   fes_lsb_pick #(.W(NB)) u_pick (
      .vec_i (pend),
      .oh_o  (pick_oh),
      .idx_o (pick_idx)
   );

   assign cmd_bank   = cmd_blk_i[BLK_W-1];
   assign cmd_loc    = cmd_blk_i[LOC_W-1:0];
   assign cmd_in_set = (cmd_bank == ebank) & eset[cmd_loc];

   assign running   = (state == ST_RUN) || (state == ST_SPEND);
   assign step_end  = running && (ecnt == EW'(ERASE_CYC - 1));
   assign pend_nx   = step_end ? (pend & ~pick_oh) : pend;
   assign failed_nx = (step_end && fail_lat[pick_idx]) ? (failed | pick_oh) : failed;
   assign done      = step_end && (pend_nx == '0);

   assign start_ok = (state == ST_IDLE) && start_i && (whole_bank_i || (blk_mask_i != '0));
   assign sus_ok   = (state == ST_RUN) && sus_i && !bmode;
   assign res_ok   = (state == ST_SUSP) && res_i && (cmd_bank == ebank) && !prog_busy;
   assign prog_ok  = (state == ST_SUSP) && prog_i && !cmd_in_set && !prog_busy;
   assign clr_ok   = (state == ST_FAIL) && rst_cmd_i;

   fes_prog_timer #(.PROG_CYC(PROG_CYC)) u_prog (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (prog_ok),
      .bank_i  (cmd_bank),
      .busy_o  (prog_busy),
      .bank_o  (pbank)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         pend     <= '0;
         eset     <= '0;
         fail_lat <= '0;
         failed   <= '0;
         ebank    <= 1'b0;
         bmode    <= 1'b0;
         ecnt     <= '0;
         scnt     <= '0;
      end else begin
         if (running) begin
            pend   <= pend_nx;
            failed <= failed_nx;
            ecnt   <= step_end ? '0 : ecnt + 1'b1;
         end
         case (state)
            ST_IDLE: begin
               if (start_ok) begin
                  state    <= ST_RUN;
                  pend     <= whole_bank_i ? '1 : blk_mask_i;
                  eset     <= whole_bank_i ? '1 : blk_mask_i;
                  fail_lat <= fail_inj_i;
                  failed   <= '0;
                  ebank    <= start_bank_i;
                  bmode    <= whole_bank_i;
                  ecnt     <= '0;
               end
            end
            ST_RUN: begin
               if (done) begin
                  state <= (failed_nx != '0) ? ST_FAIL : ST_IDLE;
               end else if (sus_ok) begin
                  state <= ST_SPEND;
                  scnt  <= '0;
               end
            end
            ST_SPEND: begin
               if (done) begin
                  state <= (failed_nx != '0) ? ST_FAIL : ST_IDLE;
               end else if (scnt == SW'(SUSP_LAT - 1)) begin
                  state <= ST_SUSP;
               end else begin
                  scnt <= scnt + 1'b1;
               end
            end
            ST_SUSP: begin
               if (res_ok) state <= ST_RUN;
            end
            ST_FAIL: begin
               if (clr_ok) begin
                  state  <= ST_IDLE;
                  failed <= '0;
                  eset   <= '0;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog6 <= 1'b0;
         tog2 <= 1'b0;
      end else if (rd_i) begin
         if (flip6) tog6 <= ~tog6;
         if (flip2) tog2 <= ~tog2;
      end
   end

   fes_status_mux #(.LOC_W(LOC_W)) u_mux (
      .state_i     (state),
      .ebank_i     (ebank),
      .eset_i      (eset),
      .failed_i    (failed),
      .prog_busy_i (prog_busy),
      .pbank_i     (pbank),
      .rd_blk_i    (rd_blk_i),
      .tog6_i      (tog6),
      .tog2_i      (tog2),
      .sel_o       (sel_status_o),
      .stat_o      (stat_o),
      .flip6_o     (flip6),
      .flip2_o     (flip2)
   );

   assign busy_o      = running;
   assign suspended_o = (state == ST_SUSP);
endmodule

// File: rtl/erase_suspend_ctl_chk.sv
module erase_suspend_ctl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       res_i,
   input logic [7:0] stat_o,
   input logic       sel_status_o,
   input logic       busy_o,
   input logic       suspended_o
);
   // R6
   busy_susp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && suspended_o));

   // R6
   susp_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(suspended_o) |-> $past(busy_o));

   // R3
   poll_low_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && sel_status_o) |-> !stat_o[7]);

   // R7
   susp_dq6_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (suspended_o && sel_status_o && stat_o[3]) |-> stat_o[6]);

   // R11
   susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (suspended_o && !res_i) |=> suspended_o);

   // R5
   fail_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_o[5] |-> (!busy_o && !suspended_o));
endmodule

bind erase_suspend_ctl erase_suspend_ctl_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .res_i        (res_i),
   .stat_o       (stat_o),
   .sel_status_o (sel_status_o),
   .busy_o       (busy_o),
   .suspended_o  (suspended_o)
);

// File: tb/erase_suspend_ctl_tb.sv
module erase_suspend_ctl_tb;
   localparam int BPB = 4;
   localparam int EC  = 16;
   localparam int SL  = 3;
   localparam int PC  = 5;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic           rst_n = 1'b0;
   logic           start_i = 1'b0, start_bank_i = 1'b0, whole_bank_i = 1'b0;
   logic [BPB-1:0] blk_mask_i = '0, fail_inj_i = '0;
   logic           sus_i = 1'b0, res_i = 1'b0, prog_i = 1'b0, rst_cmd_i = 1'b0;
   logic [2:0]     cmd_blk_i = '0;
   logic           rd_i = 1'b0;
   logic [2:0]     rd_blk_i = '0;
   logic [7:0]     stat_o;
   logic           sel_status_o, busy_o, suspended_o;

   erase_suspend_ctl #(.BLOCKS_PER_BANK(BPB), .ERASE_CYC(EC), .SUSP_LAT(SL), .PROG_CYC(PC)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_bank_i(start_bank_i),
      .whole_bank_i(whole_bank_i), .blk_mask_i(blk_mask_i), .fail_inj_i(fail_inj_i),
      .sus_i(sus_i), .res_i(res_i), .prog_i(prog_i), .rst_cmd_i(rst_cmd_i),
      .cmd_blk_i(cmd_blk_i), .rd_i(rd_i), .rd_blk_i(rd_blk_i), .stat_o(stat_o),
      .sel_status_o(sel_status_o), .busy_o(busy_o), .suspended_o(suspended_o)
   );

   int   checks = 0;
   int   errs = 0;
   int   bcnt = 0;
   logic clr = 1'b0;
   logic [7:0] rs;
   logic       rsel;
   logic       a, b;

   always @(posedge clk) begin
      if (clr) bcnt <= 0;
      else if (busy_o) bcnt <= bcnt + 1;
   end

   // {bank, whole, mask[3:0], inj[3:0], busy cycles[7:0], fails}
   localparam logic [18:0] SCN [5] = '{
      {1'b0, 1'b0, 4'b0001, 4'b0000, 8'd16, 1'b0},
      {1'b1, 1'b0, 4'b0101, 4'b0000, 8'd32, 1'b0},
      {1'b0, 1'b0, 4'b0110, 4'b0100, 8'd32, 1'b1},
      {1'b1, 1'b1, 4'b0000, 4'b0000, 8'd64, 1'b0},
      {1'b0, 1'b0, 4'b0000, 4'b0000, 8'd0,  1'b0}
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_start(input logic bk, input logic wh, input logic [3:0] m, input logic [3:0] inj);
      start_i = 1'b1; start_bank_i = bk; whole_bank_i = wh; blk_mask_i = m; fail_inj_i = inj; clr = 1'b1;
      @(negedge clk);
      start_i = 1'b0; whole_bank_i = 1'b0; clr = 1'b0;
   endtask

   // kind: 0 suspend, 1 resume, 2 program, 3 read/reset
   task automatic cmd(input int kind, input logic [2:0] blk);
      cmd_blk_i = blk;
      case (kind)
         0: sus_i = 1'b1;
         1: res_i = 1'b1;
         2: prog_i = 1'b1;
         default: rst_cmd_i = 1'b1;
      endcase
      @(negedge clk);
      sus_i = 1'b0; res_i = 1'b0; prog_i = 1'b0; rst_cmd_i = 1'b0;
   endtask

   task automatic rd(input logic [2:0] blk);
      rd_i = 1'b1; rd_blk_i = blk;
      #1;
      rs = stat_o; rsel = sel_status_o;
      @(negedge clk);
      rd_i = 1'b0;
   endtask

   task automatic wait_done();
      for (int k = 0; k < 2000; k++) begin
         if (!busy_o && !suspended_o) break;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errs++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end

   initial begin
      step(3);
      chk("R1 busy in reset", int'(busy_o), 0);
      chk("R1 suspended in reset", int'(suspended_o), 0);
      chk("R1 sel in reset", int'(sel_status_o), 0);
      rst_n = 1'b1;
      step(1);
      chk("R1 idle poll bit", int'(stat_o[7]), 1);

      // Table-driven erase scenarios (R2, R5)
      for (int i = 0; i < 5; i++) begin
         logic [18:0] e;
         e = SCN[i];
         do_start(e[18], e[17], e[16:13], e[12:9]);
         wait_done();
         chk($sformatf("R2 busy cycles scn%0d", i), bcnt, int'(e[8:1]));
         rd({e[18], 2'b00});
         chk($sformatf("R5 fail bit scn%0d", i), int'(rs[5]), int'(e[0]));
         chk($sformatf("R5 sel after end scn%0d", i), int'(rsel), int'(e[0]));
         if (e[0]) begin
            cmd(3, 3'd0);
            rd({e[18], 2'b00});
            chk($sformatf("R5 cleared fail scn%0d", i), int'(rs[5]), 0);
            chk($sformatf("R5 cleared sel scn%0d", i), int'(rsel), 0);
         end
      end

      // R3 / R4: status reads while running
      do_start(1'b0, 1'b0, 4'b0011, 4'b0000);
      rd(3'd1);
      chk("R3 sel same bank", int'(rsel), 1);
      chk("R3 poll low", int'(rs[7]), 0);
      chk("R3 timer bit", int'(rs[3]), 1);
      chk("R3 fail bit low", int'(rs[5]), 0);
      a = rs[6]; b = rs[2];
      rd(3'd1);
      chk("R4 dq6 flips", int'(rs[6]), int'(!a));
      chk("R3 dq2 flips erasing blk", int'(rs[2]), int'(!b));
      a = rs[6];
      rd(3'd2);
      chk("R4 dq6 flips other blk", int'(rs[6]), int'(!a));
      b = rs[2];
      rd(3'd2);
      chk("R3 dq2 holds non-erasing blk", int'(rs[2]), int'(b));
      rd(3'd4);
      chk("R3 other bank array", int'(rsel), 0);
      wait_done();
      chk("R2 two-block total", bcnt, 2 * EC);
      rd(3'd1);
      chk("R4 idle array", int'(rsel), 0);
      chk("R4 idle poll high", int'(rs[7]), 1);
      a = rs[6];
      rd(3'd1);
      chk("R4 idle dq6 held", int'(rs[6]), int'(a));

      // R10: commands ignored while running
      do_start(1'b1, 1'b0, 4'b0001, 4'b0001);
      step(2);
      cmd(3, 3'd4);
      cmd(1, 3'd4);
      cmd(2, 3'd6);
      start_i = 1'b1; blk_mask_i = 4'b1110;
      step(1);
      start_i = 1'b0;
      chk("R10 still busy", int'(busy_o), 1);
      wait_done();
      chk("R10 duration unchanged", bcnt, EC);
      rd(3'd4);
      chk("R10 failure kept", int'(rs[5]), 1);
      // R5: DQ2 identifies the failed block (block 4)
      b = rs[2];
      rd(3'd4);
      chk("R5 dq2 flips failed blk", int'(rs[2]), int'(!b));
      b = rs[2];
      rd(3'd5);
      chk("R5 dq2 holds good blk", int'(rs[2]), int'(!b));
      rd(3'd5);
      chk("R5 dq2 holds good blk again", int'(rs[2]), int'(!b));
      cmd(3, 3'd0);
      rd(3'd4);
      chk("R5 reset clears", int'(rsel), 0);

      // R6: suspend ignored for a whole-bank erase
      do_start(1'b1, 1'b1, 4'b0000, 4'b0000);
      step(3);
      cmd(0, 3'd0);
      step(5);
      chk("R6 bank erase no suspend", int'(suspended_o), 0);
      wait_done();
      chk("R6 bank erase total", bcnt, 4 * EC);

      // R6..R9, R11: suspend, program, resume
      do_start(1'b0, 1'b0, 4'b0011, 4'b0000);
      step(5);
      cmd(0, 3'd7);
      step(SL - 1);
      chk("R6 latency not yet", int'(suspended_o), 0);
      step(1);
      chk("R6 suspended after latency", int'(suspended_o), 1);
      chk("R6 busy low in suspend", int'(busy_o), 0);
      rd(3'd0);
      chk("R7 sel erasing blk", int'(rsel), 1);
      chk("R7 dq6 high", int'(rs[6]), 1);
      chk("R7 poll low", int'(rs[7]), 0);
      chk("R7 timer bit", int'(rs[3]), 1);
      b = rs[2];
      rd(3'd0);
      chk("R7 dq2 flips", int'(rs[2]), int'(!b));
      chk("R7 dq6 stays high", int'(rs[6]), 1);
      rd(3'd3);
      chk("R7 other blk array", int'(rsel), 0);
      cmd(3, 3'd0);
      start_i = 1'b1; blk_mask_i = 4'b0100;
      step(1);
      start_i = 1'b0;
      cmd(0, 3'd0);
      chk("R11 still suspended", int'(suspended_o), 1);
      chk("R11 not busy", int'(busy_o), 0);
      cmd(2, 3'd0);
      rd(3'd3);
      chk("R8 program on erasing blk ignored", int'(rsel), 0);
      cmd(2, 3'd2);
      rd(3'd3);
      chk("R8 program status sel", int'(rsel), 1);
      chk("R8 program timer bit", int'(rs[3]), 0);
      chk("R8 program poll low", int'(rs[7]), 0);
      a = rs[6];
      rd(3'd3);
      chk("R8 program dq6 flips", int'(rs[6]), int'(!a));
      cmd(1, 3'd1);
      chk("R9 resume refused during program", int'(suspended_o), 1);
      step(PC);
      rd(3'd3);
      chk("R8 program finished", int'(rsel), 0);
      cmd(1, 3'd5);
      chk("R9 resume wrong bank refused", int'(suspended_o), 1);
      cmd(1, 3'd1);
      chk("R9 resumed", int'(suspended_o), 0);
      chk("R9 busy again", int'(busy_o), 1);
      wait_done();
      chk("R9 progress preserved", bcnt, 2 * EC);

      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end
endmodule